// File: doc/BRIEF.md
# Synchroniser Mode Control State Machine

This block is the control state machine of a network clock synchroniser. It decides whether the oscillator loop tracks the selected reference, holds the last good frequency, or runs from the master oscillator. Five states are kept: reset, free-run, normal, holdover and auto-holdover. Some transitions are forced by a two-bit mode select. Others follow the reference monitor's ok status and its fail and recover events. The block will not enter normal while the selected reference is invalid.

The mode select and reference select pins each pass through a two-flop synchroniser. A debounce filter follows, and a new value is acted on only after it has held for `STABLE_CYCLES` clocks. When auto-return is disabled, leaving auto-holdover needs a rising edge on the manual-return input after the reference has recovered. Control and status pins are plain levels. There is no streaming data path, so no valid/ready handshake applies.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 (reset), `holdover_o` is 0 and `loop_cmd_o` is 0 (master oscillator).
- R2: After `rst_n` rises, `state_o` stays 0 for exactly `INIT_CYCLES` rising clock edges and then becomes 1 (free-run), whatever the mode select.
- R3: A filtered mode select of 2'b10 moves every state other than reset to free-run (`state_o` = 1).
- R4: In free-run, a filtered mode select of 2'b00 or 2'b01 moves to holdover (`state_o` = 3).
- R5: In holdover with mode 2'b00, a high `ref_ok` moves to normal (`state_o` = 2) and a low `ref_ok` moves to auto-holdover (`state_o` = 4). Normal is never entered while `ref_ok` is low.
- R6: In normal, mode 2'b01 or any filtered change of `ref_sel` moves to holdover.
- R7: In normal with mode 2'b00, a `ref_fail` pulse or a low `ref_ok` moves to auto-holdover.
- R8: In auto-holdover with `auto_ret_dis` low and mode 2'b00, a `ref_recover` pulse with `ref_ok` high moves to normal on the next edge. Without that pulse the state stays in auto-holdover.
- R9: With `auto_ret_dis` high, a `ref_recover` pulse alone leaves the state in auto-holdover. A later 0-to-1 edge on `man_ret`, with `ref_ok` high, moves to normal.
- R10: In auto-holdover, mode 2'b01 or a filtered change of `ref_sel` moves to holdover.
- R11: The reserved mode 2'b11 holds the current state, whatever the reference status or events.
- R12: A change on `mode_sel` or `ref_sel` that lasts fewer than `STABLE_CYCLES` clocks has no effect on the state.
- R13: `holdover_o` is 1 exactly in holdover and auto-holdover. `loop_cmd_o` is 1 (track) in normal, 2 (hold) in holdover and auto-holdover, and 0 (master) in reset and free-run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; forces the reset state |
| mode_sel | input | 2 | Mode select: 00 normal, 01 holdover, 10 free-run, 11 reserved |
| ref_sel | input | 1 | Reference select; a change counts as a reference switch |
| ref_ok | input | 1 | Selected reference is valid |
| ref_fail | input | 1 | One-cycle pulse: reference went from ok to failed |
| ref_recover | input | 1 | One-cycle pulse: reference went from failed to ok |
| auto_ret_dis | input | 1 | High disables the automatic return from auto-holdover |
| man_ret | input | 1 | Manual return request; its rising edge acts |
| state_o | output | 3 | 0 reset, 1 free-run, 2 normal, 3 holdover, 4 auto-holdover |
| holdover_o | output | 1 | High in holdover and auto-holdover |
| loop_cmd_o | output | 2 | 0 master oscillator, 1 track reference, 2 hold frequency |

## Verification
The hardest case to reach is the brief pass through holdover when `ref_sel` toggles in normal. With a good reference, the machine returns to normal one clock later, so a check made after a fixed delay cannot see the holdover visit. The bench therefore polls the state on every clock after the pin change and records whether holdover appeared. It then confirms the return to normal. Manual return is reached by disabling auto-return, sending a recover pulse, confirming the machine stays in auto-holdover, and only then raising `man_ret`.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_FREERUN  = 3'd1,
    ST_NORMAL   = 3'd2,
    ST_HOLDOVER = 3'd3,
    ST_AUTOHOLD = 3'd4
  } smc_state_e;

  typedef enum logic [1:0] {
    LOOP_MASTER = 2'd0,
    LOOP_TRACK  = 2'd1,
    LOOP_HOLD   = 2'd2
  } loop_cmd_e;

  localparam logic [1:0] MODE_NORM = 2'b00;
  localparam logic [1:0] MODE_HOLD = 2'b01;
  localparam logic [1:0] MODE_FREE = 2'b10;
  localparam logic [1:0] MODE_RSVD = 2'b11;
endpackage

// File: rtl/smc_pin_filter.sv
// Two-flop synchroniser followed by a stability filter.
module smc_pin_filter #(
  parameter int          W        = 1,
  parameter int          STABLE   = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] filt_o,
  output logic         chg_o
);
  localparam int CW = $clog2(STABLE + 1);

  logic [W-1:0] s1_q, s2_q, prev_q, filt_q;
  logic [CW-1:0] cnt_q;
  logic          chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= RST_VAL;
      s2_q   <= RST_VAL;
      prev_q <= RST_VAL;
      filt_q <= RST_VAL;
      cnt_q  <= '0;
      chg_q  <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      chg_q  <= 1'b0;
      if (s2_q != prev_q || s2_q == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(STABLE - 1)) begin
        filt_q <= s2_q;
        chg_q  <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;
  assign chg_o  = chg_q;
endmodule

// File: rtl/smc_init_timer.sv
// Counts the initialisation period that follows reset release.
module smc_init_timer #(
  parameter int INIT_CYCLES = 156250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(INIT_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (run_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/smc_fsm.sv
// Next-state logic for the five-state mode controller.
module smc_fsm
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_done_i,
  input  logic [1:0] mode_i,
  input  logic       sel_chg_i,
  input  logic       ref_ok_i,
  input  logic       fail_i,
  input  logic       recover_i,
  input  logic       auto_dis_i,
  input  logic       man_ret_i,
  output smc_state_e state_o
);
  smc_state_e state_q, state_d;
  logic       man_q, armed_q, armed_d, man_rise;

  assign man_rise = man_ret_i & ~man_q;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_RESET) begin
      if (init_done_i) state_d = ST_FREERUN;
    end else if (mode_i == MODE_FREE) begin
      state_d = ST_FREERUN;
    end else if (mode_i != MODE_RSVD) begin
      unique case (state_q)
        ST_FREERUN:  state_d = ST_HOLDOVER;
        ST_HOLDOVER: begin
          if (mode_i == MODE_NORM) state_d = ref_ok_i ? ST_NORMAL : ST_AUTOHOLD;
        end
        ST_NORMAL: begin
          if (mode_i == MODE_HOLD || sel_chg_i) state_d = ST_HOLDOVER;
          else if (fail_i || !ref_ok_i)         state_d = ST_AUTOHOLD;
        end
        ST_AUTOHOLD: begin
          if (mode_i == MODE_HOLD || sel_chg_i) begin
            state_d = ST_HOLDOVER;
          end else if (ref_ok_i && !fail_i) begin
            if (!auto_dis_i && recover_i)           state_d = ST_NORMAL;
            else if (auto_dis_i && armed_q && man_rise) state_d = ST_NORMAL;
          end
        end
        default: state_d = ST_FREERUN;
      endcase
    end
  end

  // Recovery seen while parked in auto-holdover; manual return needs it.
  always_comb begin
    armed_d = armed_q;
    if (state_q != ST_AUTOHOLD || fail_i) armed_d = 1'b0;
    else if (recover_i && ref_ok_i)       armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      man_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      man_q   <= man_ret_i;
      armed_q <= armed_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/smc_out_decode.sv
// Maps the state onto the status flag and the loop command.
module smc_out_decode
  import smc_pkg::*;
(
  input  smc_state_e state_i,
  output logic       holdover_o,
  output loop_cmd_e  cmd_o
);
  always_comb begin
    holdover_o = 1'b0;
    cmd_o      = LOOP_MASTER;
    unique case (state_i)
      ST_NORMAL:   cmd_o = LOOP_TRACK;
      ST_HOLDOVER,
      ST_AUTOHOLD: begin
        cmd_o      = LOOP_HOLD;
        holdover_o = 1'b1;
      end
      default:     cmd_o = LOOP_MASTER;
    endcase
  end
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import smc_pkg::*;
#(
  parameter int INIT_CYCLES   = 156250,
  parameter int STABLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       ref_sel,
  input  logic       ref_ok,
  input  logic       ref_fail,
  input  logic       ref_recover,
  input  logic       auto_ret_dis,
  input  logic       man_ret,
  output logic [2:0] state_o,
  output logic       holdover_o,
  output logic [1:0] loop_cmd_o
);
  logic [1:0] mode_f;
  logic       sel_f, sel_chg, mode_chg_unused, init_done;
  smc_state_e st;
  loop_cmd_e  cmd;

  smc_pin_filter #(.W(2), .STABLE(STABLE_CYCLES), .RST_VAL(MODE_FREE)) u_mode_flt (
    .clk(clk), .rst_n(rst_n), .pin_i(mode_sel), .filt_o(mode_f), .chg_o(mode_chg_unused)
  );

  smc_pin_filter #(.W(1), .STABLE(STABLE_CYCLES), .RST_VAL(1'b0)) u_sel_flt (
    .clk(clk), .rst_n(rst_n), .pin_i(ref_sel), .filt_o(sel_f), .chg_o(sel_chg)
  );

  smc_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_n), .run_i(st == ST_RESET), .done_o(init_done)
  );

  smc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .init_done_i(init_done), .mode_i(mode_f),
    .sel_chg_i(sel_chg), .ref_ok_i(ref_ok), .fail_i(ref_fail),
    .recover_i(ref_recover), .auto_dis_i(auto_ret_dis), .man_ret_i(man_ret),
    .state_o(st)
  );

  smc_out_decode u_dec (
    .state_i(st), .holdover_o(holdover_o), .cmd_o(cmd)
  );

  assign state_o    = st;
  assign loop_cmd_o = cmd;

  logic unused_ok;
  assign unused_ok = &{1'b0, sel_f, mode_chg_unused};
endmodule

// File: rtl/sync_mode_ctrl_chk.sv
module sync_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state_o,
  input logic       holdover_o,
  input logic [1:0] loop_cmd_o,
  input logic       ref_ok,
  input logic [1:0] mode_f
);
  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) == 1'b0) |-> state_o == 3'd0); // R1

  AST_INIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 3'd0 && state_o != 3'd0) |-> state_o == 3'd1); // R2

  AST_FORCE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_f == 2'b10 && state_o != 3'd0) |=> state_o == 3'd1); // R3

  AST_FREE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && !mode_f[1]) |=> state_o == 3'd3); // R4

  AST_NORMAL_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && $past(state_o) != 3'd2) |-> $past(ref_ok)); // R5

  AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_f == 2'b11 && state_o != 3'd0) |=> $stable(state_o)); // R11

  AST_FLAG_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    holdover_o |-> loop_cmd_o == 2'd2); // R13
endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .holdover_o(holdover_o),
  .loop_cmd_o(loop_cmd_o), .ref_ok(ref_ok), .mode_f(mode_f)
);

// File: tb/sim_sync_mode_ctrl.sv
`timescale 1ns/1ps
module sim_sync_mode_ctrl;
  localparam int INIT = 40;
  localparam int STAB = 4;
  localparam logic [2:0] S_RST = 3'd0, S_FREE = 3'd1, S_NORM = 3'd2,
                         S_HOLD = 3'd3, S_AUTO = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b10;
  logic ref_sel = 1'b0, ref_ok = 1'b0, ref_fail = 1'b0, ref_recover = 1'b0;
  logic auto_ret_dis = 1'b0, man_ret = 1'b0;
  logic [2:0] state_o;
  logic holdover_o;
  logic [1:0] loop_cmd_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sync_mode_ctrl #(.INIT_CYCLES(INIT), .STABLE_CYCLES(STAB)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_sel(ref_sel),
    .ref_ok(ref_ok), .ref_fail(ref_fail), .ref_recover(ref_recover),
    .auto_ret_dis(auto_ret_dis), .man_ret(man_ret),
    .state_o(state_o), .holdover_o(holdover_o), .loop_cmd_o(loop_cmd_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fail();
    ref_fail = 1'b1; cyc(1); ref_fail = 1'b0;
  endtask

  task automatic pulse_recover();
    ref_recover = 1'b1; cyc(1); ref_recover = 1'b0;
  endtask

  // Poll every clock; report whether a state appeared within n cycles.
  task automatic seen(input logic [2:0] st, input int n, output bit hit);
    hit = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (state_o == st) hit = 1;
    end
  endtask

  task automatic t_reset();
    cyc(5);
    chk("R1 state", state_o, S_RST);
    chk("R1 flag", holdover_o, 0);
    chk("R1 cmd", loop_cmd_o, 0);
    rst_n = 1'b1;
    cyc(INIT - 1);
    chk("R2 still reset", state_o, S_RST);
    cyc(1);
    chk("R2 freerun", state_o, S_FREE);
    chk("R13 freerun cmd", loop_cmd_o, 0);
  endtask

  task automatic t_free_to_hold();
    mode_sel = 2'b01; cyc(20);
    chk("R4 holdover", state_o, S_HOLD);
    chk("R13 hold flag", holdover_o, 1);
    chk("R13 hold cmd", loop_cmd_o, 2);
  endtask

  task automatic t_invalid_ref();
    bit hit;
    ref_ok = 1'b0; mode_sel = 2'b00;
    seen(S_NORM, 30, hit);
    chk("R5 no normal on bad ref", hit, 0);
    chk("R5 auto-holdover", state_o, S_AUTO);
    chk("R13 auto flag", holdover_o, 1);
  endtask

  task automatic t_auto_return();
    ref_ok = 1'b1; cyc(5);
    chk("R8 waits for event", state_o, S_AUTO);
    pulse_recover(); cyc(1);
    chk("R8 back to normal", state_o, S_NORM);
    chk("R13 normal cmd", loop_cmd_o, 1);
    chk("R13 normal flag", holdover_o, 0);
  endtask

  task automatic t_fail();
    ref_ok = 1'b0; pulse_fail(); cyc(1);
    chk("R7 auto on fail", state_o, S_AUTO);
  endtask

  task automatic t_manual();
    auto_ret_dis = 1'b1; ref_ok = 1'b1;
    pulse_recover(); cyc(5);
    chk("R9 stays auto", state_o, S_AUTO);
    man_ret = 1'b1; cyc(3);
    chk("R9 manual return", state_o, S_NORM);
    man_ret = 1'b0; auto_ret_dis = 1'b0; cyc(2);
  endtask

  task automatic t_sel_change();
    bit hit;
    ref_sel = ~ref_sel;
    seen(S_HOLD, 20, hit);
    chk("R6 sel change visits holdover", hit, 1);
    cyc(5);
    chk("R5 relock normal", state_o, S_NORM);
  endtask

  task automatic t_normal_mode_hold();
    mode_sel = 2'b01; cyc(20);
    chk("R6 mode hold", state_o, S_HOLD);
    mode_sel = 2'b00; cyc(20);
    chk("R5 hold to normal", state_o, S_NORM);
  endtask

  task automatic t_auto_exit();
    pulse_fail(); cyc(1);
    chk("R7 fail with ok high", state_o, S_AUTO);
    mode_sel = 2'b01; cyc(20);
    chk("R10 auto to holdover", state_o, S_HOLD);
    mode_sel = 2'b00; cyc(20);
    chk("R5 normal again", state_o, S_NORM);
  endtask

  task automatic t_reserved();
    mode_sel = 2'b11; cyc(20);
    ref_ok = 1'b0; pulse_fail(); cyc(10);
    chk("R11 reserved holds", state_o, S_NORM);
    ref_ok = 1'b1; mode_sel = 2'b00; cyc(20);
    chk("R11 normal after reserved", state_o, S_NORM);
  endtask

  task automatic t_glitch();
    bit hit;
    mode_sel = 2'b10; cyc(2); mode_sel = 2'b00; cyc(20);
    chk("R12 mode glitch ignored", state_o, S_NORM);
    ref_sel = ~ref_sel; cyc(2); ref_sel = ~ref_sel;
    seen(S_HOLD, 20, hit);
    chk("R12 sel glitch ignored", hit, 0);
  endtask

  task automatic t_force_free();
    mode_sel = 2'b10; cyc(20);
    chk("R3 forced freerun", state_o, S_FREE);
    chk("R13 master cmd", loop_cmd_o, 0);
  endtask

  initial begin
    t_reset();
    t_free_to_hold();
    t_invalid_ref();
    t_auto_return();
    t_fail();
    t_manual();
    t_sel_change();
    t_normal_mode_hold();
    t_auto_exit();
    t_reserved();
    t_glitch();
    t_force_free();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule